// File: doc/BRIEF.md
# Decrement-and-Skip Execution Unit

This block is a small fetch-and-execute slice of an 8-bit accumulator-style core. It fetches 16-bit instruction words from a synchronous program memory, holds one prefetched word, and runs two instructions against a banked byte-wide data memory: "decrement, skip next if the result is zero" and "decrement, skip next if the result is nonzero". Every instruction slot lasts four clocks. The four phases are decode, operand read, arithmetic and write-back. While one word executes, the next word is fetched.

A taken skip turns the prefetched word into a bubble. If that word is the head of a two-word instruction, its second word is squashed as well. A skip therefore costs one extra slot, or two extra slots when the skipped instruction is two words long. The result of each decrement goes either to the working register or back into the file register. A per-instruction access bit selects between the bank-select input and a fixed access window. All other opcodes retire as one-slot no-ops. No status flags are kept.

A preload port lets the surrounding chip fill the data memory. The write-back strobe and the working register are visible at the ports so that results can be observed.

Top module: `dskip_core`

## Requirements
- R1: Word pattern 0010_11da_ffff_ffff (bits 15:10 = 001011) is decrement-skip-if-zero, and 0100_11da_ffff_ffff (bits 15:10 = 010011) is decrement-skip-if-nonzero, with d = bit 9, a = bit 8 and f = bits 7:0. Any other word retires without writing memory or W and without causing a skip.
- R2: Both instructions compute the addressed byte minus one, modulo 256, so 0x00 becomes 0xFF.
- R3: With d = 0 the result goes to W and no file write occurs. With d = 1 the result is written to the file register and W keeps its value. W changes only at the end of a slot.
- R4: With a = 0 the bank-select input is ignored. f < 0x80 addresses {0x0, f} and f >= 0x80 addresses {0xF, f}.
- R5: With a = 1 the 12-bit data address is {bsr_i, f}.
- R6: The zero variant skips when the result is 0x00, and the nonzero variant skips when the result is not 0x00.
- R7: A skip replaces the prefetched word by a bubble slot (slot_nop_o high, no write), so a skipping instruction costs two slots.
- R8: If the squashed word has bits 15:12 = 1100 (head of a two-word instruction), the following word is also squashed, which makes three slots in total.
- R9: A slot is four clocks. slot_end_o pulses on the fourth clock. imem_addr is stable within a slot and advances by one word at each slot end.
- R10: While rst_n is low, imem_addr is 0, W is 0 and slot_end_o is 0. The first slot after reset is a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bsr_i | input | BSRW | Bank-select value used when a = 1 |
| imem_addr | output | PCW | Program word address (program counter) |
| imem_rdata | input | 16 | Program word, one clock after the address |
| ld_en | input | 1 | Data memory preload strobe |
| ld_addr | input | BSRW+8 | Preload address |
| ld_data | input | 8 | Preload byte |
| w_o | output | 8 | Working register |
| slot_end_o | output | 1 | High in the last clock of each slot |
| slot_nop_o | output | 1 | Current slot is a bubble (squashed or post-reset) |
| fwr_en_o | output | 1 | File write-back strobe |
| fwr_addr_o | output | BSRW+8 | File write-back address |
| fwr_data_o | output | 8 | File write-back byte |

## Verification
The bench builds the unit with its default parameters: a 4-bit bank select, which gives sixteen 256-byte banks, and a 10-bit program counter. The 4-bit bank select makes the top bank of the access window and the banked addresses reachable. A 64-word program is run twice with two different bank-select values. The program covers both skip senses, both destinations, both access modes, a wrap from 0x00 to 0xFF, a skip over a two-word instruction, and a two-word instruction that is not skipped. An instruction-level model runs beside the unit and is compared on every clock. Hand-computed bubble positions, write addresses and the final program counter are also checked.

// File: rtl/dskip_pkg.sv
package dskip_pkg;

  localparam logic [5:0] OPC_DEC_Z  = 6'b001011;
  localparam logic [5:0] OPC_DEC_NZ = 6'b010011;
  localparam logic [3:0] HEAD_2W    = 4'b1100;

  typedef struct packed {
    logic       is_dec;
    logic       skip_zero;
    logic       to_file;
    logic       use_bsr;
    logic [7:0] faddr;
    logic       head2;
  } op_t;

  function automatic op_t decode_op(input logic [15:0] iw);
    op_t o;
    o.is_dec    = (iw[15:10] == OPC_DEC_Z) || (iw[15:10] == OPC_DEC_NZ);
    o.skip_zero = (iw[15:10] == OPC_DEC_Z);
    o.to_file   = iw[9];
    o.use_bsr   = iw[8];
    o.faddr     = iw[7:0];
    o.head2     = (iw[15:12] == HEAD_2W);
    return o;
  endfunction

endpackage

// File: rtl/dskip_seq.sv
module dskip_seq
  import dskip_pkg::*;
#(
  parameter int PCW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           skip_i,
  input  logic [15:0]    rdata_i,
  output logic [1:0]     phase_o,
  output logic [PCW-1:0] pc_o,
  output logic [15:0]    ir_o,
  output logic           kill_o,
  output logic           slot_end_o
);

  localparam logic [1:0] LAST_PH = 2'd3;

  logic [1:0]     q_r, q_n;
  logic [PCW-1:0] pc_r, pc_n;
  logic [15:0]    ir_r, ir_n;
  logic           kill_r, kill_n;
  logic           end_s;

  assign end_s = (q_r == LAST_PH);

  always_comb begin
    q_n    = q_r + 2'd1;
    pc_n   = pc_r + 1'b1;
    ir_n   = rdata_i;
    kill_n = skip_i | (kill_r & (ir_r[15:12] == HEAD_2W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= 2'd0;
      pc_r   <= '0;
      ir_r   <= '0;
      kill_r <= 1'b1;
    end else begin
      q_r <= q_n;
      if (end_s) begin
        pc_r   <= pc_n;
        ir_r   <= ir_n;
        kill_r <= kill_n;
      end
    end
  end

  assign phase_o    = q_r;
  assign pc_o       = pc_r;
  assign ir_o       = ir_r;
  assign kill_o     = kill_r;
  assign slot_end_o = end_s;

  assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end_o |=> pc_o == $past(pc_o) + 1'b1);

  assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end_o |=> $stable(pc_o));

  assert_kill_after_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end_o && skip_i) |=> kill_o);

  assert_kill_second_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end_o && kill_o && ir_o[15:12] == 4'hC) |=> kill_o);

endmodule

// File: rtl/dskip_bank.sv
module dskip_bank #(
  parameter int BSRW = 4,
  parameter int DW   = 8
) (
  input  logic               clk,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic               use_bsr,
  input  logic [7:0]         faddr,
  input  logic [BSRW-1:0]    bsr,
  input  logic [DW-1:0]      wdata,
  input  logic               ld_en,
  input  logic [BSRW+7:0]    ld_addr,
  input  logic [DW-1:0]      ld_data,
  output logic [DW-1:0]      rdata_q,
  output logic [BSRW+7:0]    addr_o
);

  localparam int ADW   = BSRW + 8;
  localparam int DEPTH = 1 << ADW;

  logic [DW-1:0]  mem [DEPTH];
  logic [ADW-1:0] addr_s;

  always_comb begin
    if (use_bsr) addr_s = {bsr, faddr};
    else         addr_s = {{BSRW{faddr[7]}}, faddr};
  end

  always_ff @(posedge clk) begin
    if (wr_en)      mem[addr_s]  <= wdata;
    else if (ld_en) mem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata_q <= mem[addr_s];
  end

  assign addr_o = addr_s;

endmodule

// File: rtl/dskip_core.sv
module dskip_core
  import dskip_pkg::*;
#(
  parameter int PCW  = 10,
  parameter int BSRW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BSRW-1:0]  bsr_i,
  output logic [PCW-1:0]   imem_addr,
  input  logic [15:0]      imem_rdata,
  input  logic             ld_en,
  input  logic [BSRW+7:0]  ld_addr,
  input  logic [7:0]       ld_data,
  output logic [7:0]       w_o,
  output logic             slot_end_o,
  output logic             slot_nop_o,
  output logic             fwr_en_o,
  output logic [BSRW+7:0]  fwr_addr_o,
  output logic [7:0]       fwr_data_o
);

  localparam logic [1:0] PH_READ = 2'd1;
  localparam logic [1:0] PH_ALU  = 2'd2;

  logic        rs1_r, rs2_r;
  logic        srst_n;
  logic [1:0]  phase;
  logic [15:0] ir;
  logic        kill, slot_end;
  op_t         op;
  logic        exec, res_zero, skip;
  logic [7:0]  rd_q, res_r, w_r;
  logic        wr_file, wr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_r <= 1'b0;
      rs2_r <= 1'b0;
    end else begin
      rs1_r <= 1'b1;
      rs2_r <= rs1_r;
    end
  end
  assign srst_n = rs2_r;

  dskip_seq #(.PCW(PCW)) u_seq (
    .clk        (clk),
    .rst_n      (srst_n),
    .skip_i     (skip),
    .rdata_i    (imem_rdata),
    .phase_o    (phase),
    .pc_o       (imem_addr),
    .ir_o       (ir),
    .kill_o     (kill),
    .slot_end_o (slot_end)
  );

  assign op       = decode_op(ir);
  assign exec     = op.is_dec & ~kill;
  assign res_zero = (res_r == 8'h00);
  assign skip     = exec & (op.skip_zero ? res_zero : ~res_zero);
  assign wr_file  = slot_end & exec & op.to_file;
  assign wr_w     = slot_end & exec & ~op.to_file;

  dskip_bank #(.BSRW(BSRW), .DW(8)) u_bank (
    .clk     (clk),
    .rd_en   (phase == PH_READ),
    .wr_en   (wr_file),
    .use_bsr (op.use_bsr),
    .faddr   (op.faddr),
    .bsr     (bsr_i),
    .wdata   (res_r),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .rdata_q (rd_q),
    .addr_o  (fwr_addr_o)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      res_r <= 8'h00;
      w_r   <= 8'h00;
    end else begin
      if (phase == PH_ALU) res_r <= rd_q - 8'd1;
      if (wr_w)            w_r   <= res_r;
    end
  end

  assign w_o        = w_r;
  assign slot_end_o = slot_end;
  assign slot_nop_o = kill;
  assign fwr_en_o   = wr_file;
  assign fwr_data_o = res_r;

  assert_nop_silent_R7: assert property (@(posedge clk) disable iff (!srst_n)
    fwr_en_o |-> !slot_nop_o);

  assert_w_hold_R3: assert property (@(posedge clk) disable iff (!srst_n)
    !slot_end_o |=> $stable(w_o));

  assert_dec_value_R2: assert property (@(posedge clk) disable iff (!srst_n)
    fwr_en_o |-> fwr_data_o == rd_q - 8'd1);

endmodule

// File: tb/tb_dskip_core.sv
module tb_dskip_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bsr = 4'd0;
  logic [9:0]  imem_addr;
  logic [15:0] imem_rdata;
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [7:0]  w_o;
  logic        slot_end_o, slot_nop_o, fwr_en_o;
  logic [11:0] fwr_addr_o;
  logic [7:0]  fwr_data_o;

  always #5 clk = ~clk;

  dskip_core dut (
    .clk(clk), .rst_n(rst_n), .bsr_i(bsr), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .w_o(w_o), .slot_end_o(slot_end_o),
    .slot_nop_o(slot_nop_o), .fwr_en_o(fwr_en_o),
    .fwr_addr_o(fwr_addr_o), .fwr_data_o(fwr_data_o)
  );

  logic [15:0] pmem [64];
  logic [7:0]  mdm  [4096];
  int checks = 0, failures = 0;
  int npe = 0, ea = -1, slot = 0;
  bit mkill = 1, running = 0;
  logic [7:0] mw = 8'h00;
  bit         nophist [64];
  bit         fwen_h  [64];
  logic [11:0] fwad_h [64];
  logic [7:0]  fwdt_h [64];

  always @(posedge clk) imem_rdata <= pmem[imem_addr[5:0]];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) npe = 0; else npe = npe + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input int i);
    case (i)
      12'h005: return 8'd3;
      12'hF85: return 8'd1;
      12'h210: return 8'd0;
      12'h211: return 8'd1;
      12'h212: return 8'd1;
      12'h213: return 8'd5;
      default: return 8'((i * 37 + 11) & 255);
    endcase
  endfunction

  task automatic model_slot();
    logic [15:0] wd;
    bit dec, zs, skip, ex_en;
    logic [11:0] a;
    logic [7:0] res;
    wd = (ea < 0) ? 16'h0000 : pmem[ea];
    dec = (wd[15:10] == 6'b001011) || (wd[15:10] == 6'b010011);
    zs = (wd[15:10] == 6'b001011);
    a = wd[8] ? {bsr, wd[7:0]} : {{4{wd[7]}}, wd[7:0]};
    res = mdm[a] - 8'd1;
    skip = 0; ex_en = 0;
    check(slot_nop_o == mkill, "R7 bubble slot", slot_nop_o, mkill);
    if (!mkill && dec) begin
      skip = zs ? (res == 0) : (res != 0);
      if (wd[9]) begin ex_en = 1; mdm[a] = res; end
      else mw = res;
    end
    check(fwr_en_o == ex_en, "R1 write strobe", fwr_en_o, ex_en);
    if (ex_en) begin
      check(fwr_addr_o == a, "R5 address", fwr_addr_o, a);
      check(fwr_data_o == res, "R2 value", fwr_data_o, res);
    end
    nophist[slot] = slot_nop_o;
    fwen_h[slot] = fwr_en_o; fwad_h[slot] = fwr_addr_o; fwdt_h[slot] = fwr_data_o;
    mkill = skip | (mkill & (wd[15:12] == 4'hC));
    ea++; slot++;
  endtask

  always @(negedge clk) begin
    if (running) begin
      int ph;
      ph = (npe < 2) ? 0 : (npe - 2) % 4;
      check(imem_addr == 10'(ea + 1), "R9 pc", imem_addr, ea + 1);
      check(slot_end_o == (ph == 3), "R9 slot end", slot_end_o, ph == 3);
      check(w_o == mw, "R3 W", w_o, mw);
      if (ph == 3) model_slot();
    end
  end

  task automatic run_prog(input logic [3:0] b, input int nslots);
    rst_n = 0; running = 0; bsr = b;
    @(negedge clk);
    for (int i = 0; i < 4096; i++) begin
      ld_en = 1; ld_addr = 12'(i); ld_data = init_val(i); mdm[i] = init_val(i);
      @(negedge clk);
    end
    ld_en = 0;
    check(imem_addr == 0, "R10 reset pc", imem_addr, 0);
    check(w_o == 0, "R10 reset W", w_o, 0);
    check(slot_end_o == 0, "R10 reset slot end", slot_end_o, 0);
    ea = -1; mkill = 1; mw = 0; slot = 0;
    rst_n = 1; running = 1;
    wait (slot == nslots);
    @(negedge clk);
    running = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) pmem[i] = 16'h0000;
    pmem[0]  = 16'h2E05; pmem[1]  = 16'h2E85; pmem[2]  = 16'h2E05;
    pmem[3]  = 16'h4D10; pmem[4]  = 16'hC000; pmem[5]  = 16'hF000;
    pmem[6]  = 16'h4F11; pmem[7]  = 16'h2C05; pmem[8]  = 16'hC000;
    pmem[9]  = 16'hF000; pmem[10] = 16'h2F12; pmem[11] = 16'hC000;
    pmem[12] = 16'hF000; pmem[13] = 16'h2F13;

    run_prog(4'd2, 20);
    begin
      int n;
      n = 0;
      for (int s = 0; s < 20; s++) n += nophist[s];
      check(n == 6, "R7 bubble count", n, 6);
    end
    check(imem_addr == 10'd20, "R9 final pc", imem_addr, 20);
    check(w_o == 8'h01, "R3 final W", w_o, 1);
    check(nophist[0] == 1, "R10 first slot bubble", nophist[0], 1);
    check(nophist[3] == 1 && nophist[4] == 0, "R7 one extra slot", nophist[4], 0);
    check(nophist[5] == 1 && nophist[6] == 1 && nophist[7] == 0, "R8 two extra slots", nophist[6], 1);
    check(nophist[12] == 1 && nophist[13] == 1, "R8 second skip", nophist[13], 1);
    check(fwen_h[1] && fwad_h[1] == 12'h005 && fwdt_h[1] == 8'd2, "R4 low access", fwad_h[1], 12'h005);
    check(fwen_h[2] && fwad_h[2] == 12'hF85 && fwdt_h[2] == 8'd0, "R6 zero skip source", fwdt_h[2], 0);
    check(fwen_h[7] && fwad_h[7] == 12'h211, "R5 banked", fwad_h[7], 12'h211);
    check(nophist[7] == 0 && nophist[8] == 0, "R6 nonzero variant no skip on zero", nophist[8], 0);
    check(fwen_h[8] == 0, "R3 d=0 no file write", fwen_h[8], 0);
    check(fwen_h[9] == 0 && fwen_h[10] == 0 && nophist[10] == 0, "R1 other opcodes inert", fwen_h[9], 0);

    run_prog(4'd5, 20);
    check(fwen_h[2] && fwad_h[2] == 12'hF85, "R4 bsr ignored", fwad_h[2], 12'hF85);
    check(fwen_h[7] && fwad_h[7] == 12'h511, "R5 banked other bsr", fwad_h[7], 12'h511);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule